// File: doc/BRIEF.md
# SD/MMC Command Issue Gate

This block decides the cycle in which a queued SD/MMC command may go out on the CMD line. A command request arrives with two wait options. The first holds the command while the card signals busy by pulling DAT0 low. The second holds it until the data engine reports that the current block has passed its CRC check, which lets a STOP command be placed in the middle of a multi-block read. A programmable limit bounds how long a request may wait. If the data block fails its CRC while a command is waiting for it, the command is dropped.

Two other tasks run beside the launch decision. After a block write, the gate reads the card's CRC status token from DAT0 and reports whether the card accepted the block. Software can turn this check off for each block. When card interrupts are enabled and no data transfer is running, the gate watches DAT1 and keeps a sticky interrupt flag that is cleared by a write-one strobe.

Top module: `sdcmd_issue_gate`

## Requirements
- R1: With both wait options low, a request sampled in one cycle raises `cmd_launch` for exactly one cycle in the next cycle.
- R2: With `wait_ready` set, `cmd_launch` stays low in every pending cycle where `dat0` is 0. The command launches in the first pending cycle with `dat0` at 1.
- R3: With `wait_data` set, the command launches in the first pending cycle in which a clean `crc_pass` (with `crc_fail` low) is seen, or in any later pending cycle. A pass strobe seen before the request does not count.
- R4: With both options set, the command launches only when both conditions hold in the same pending cycle. A pass seen earlier in the pending window is remembered.
- R5: If `crc_fail` arrives while a `wait_data` command still has no pass, `cmd_abort` pulses for one cycle, no launch follows, and the gate returns to idle.
- R6: Pending cycles are numbered from 0. If the command has not launched by pending cycle number `busy_limit`, `cmd_timeout` pulses in that cycle and the command is cancelled.
- R7: A request that arrives while a command is pending is ignored. The held options do not change.
- R8: After `blk_wr_done` with `skip_token` low, the token check runs in this order. The first later cycle with `dat0` at 0 is the start bit. The next three cycles give the status bits, first bit as MSB. The cycle after them is the end bit. One cycle after the end bit, `wst_valid` pulses. `wst_err` is 0 only for status 3'b010 with an end bit of 1, and it holds its value until the next result.
- R9: With `skip_token` high at `blk_wr_done`, no token is read and `wst_valid` stays low whatever `dat0` does.
- R10: When `irq_en` is 1, `xfer_active` is 0 and `dat1` is 0 in a cycle, `sdio_irq` is 1 from the next cycle on.
- R11: `sdio_irq` is cleared by `irq_clr`, but a new set condition in the same cycle wins. While `irq_en` is 0 or `xfer_active` is 1, the flag cannot become set.
- R12: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_req | input | 1 | Command request strobe |
| wait_ready | input | 1 | Hold launch while card is busy (DAT0 low) |
| wait_data | input | 1 | Hold launch until the data block passes its CRC |
| busy_limit | input | TMO_W | Last pending cycle number before a timeout |
| crc_pass | input | 1 | Data engine: block CRC phase finished good |
| crc_fail | input | 1 | Data engine: block CRC phase finished bad |
| blk_wr_done | input | 1 | Data engine: a write block has finished |
| skip_token | input | 1 | Do not read a CRC status token for this block |
| dat0 | input | 1 | Sampled DAT0 level |
| dat1 | input | 1 | Sampled DAT1 level |
| xfer_active | input | 1 | A data transfer is in progress |
| irq_en | input | 1 | Enable card-interrupt detection |
| irq_clr | input | 1 | Write-one clear of the interrupt flag |
| cmd_launch | output | 1 | One-cycle strobe: send the command now |
| cmd_abort | output | 1 | One-cycle strobe: command dropped on a data CRC failure |
| cmd_timeout | output | 1 | One-cycle strobe: command cancelled at the wait limit |
| wst_valid | output | 1 | One-cycle strobe: write-status token decoded |
| wst_err | output | 1 | Result of the last token, 1 = rejected or malformed |
| sdio_irq | output | 1 | Sticky card-interrupt flag |

## Verification
The launch path is tried with each combination of the wait options. Busy is released before and after a data pass, so a gate that checks only one condition, or forgets a pass seen earlier, launches in the wrong cycle. A pass strobe sent before the request, a failure strobe during a data wait, and a busy period longer than the limit show whether stale, abort and timeout events are handled correctly. The token reader gets an accepted pattern, a rejected status and a bad end bit, plus a skipped block with a hostile DAT0 pattern. The interrupt flag is driven while masked by transfer activity, while disabled, and with a clear in the same cycle as a new set.

// File: rtl/sdg_pkg.sv
`timescale 1ns/1ps
package sdg_pkg;

  // token reader states
  typedef enum logic [1:0] {TK_IDLE, TK_HUNT, TK_BITS, TK_END} tok_st_t;

  localparam int          TOK_STAT_W = 3;
  localparam logic [2:0]  TOK_ACCEPT = 3'b010;

  // busy condition: satisfied when not requested or card released DAT0
  function automatic logic ready_ok(input logic want_ready, input logic d0);
    return !want_ready || d0;
  endfunction

  // data condition: satisfied when not requested, already seen, or seen now
  function automatic logic data_ok(input logic want_data, input logic seen,
                                   input logic pass_now);
    return !want_data || seen || pass_now;
  endfunction

  // token verdict: anything but accept pattern with good end bit is an error
  function automatic logic tok_rejected(input logic [2:0] stat, input logic endb);
    return (stat != TOK_ACCEPT) || !endb;
  endfunction

endpackage

// File: rtl/sdg_launch_ctl.sv
`timescale 1ns/1ps
module sdg_launch_ctl #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_req,
  input  logic             wait_ready,
  input  logic             wait_data,
  input  logic [TMO_W-1:0] busy_limit,
  input  logic             crc_pass,
  input  logic             crc_fail,
  input  logic             dat0,
  output logic             cmd_launch,
  output logic             cmd_abort,
  output logic             cmd_timeout
);
  import sdg_pkg::*;

  logic             pend_q, wr_q, wd_q, dmet_q;
  logic [TMO_W-1:0] cnt_q;

  // named internal events
  logic pass_clean, cond_ready, cond_data, gate_open;
  logic abort_ev, launch_ev, expire_ev, accept_ev;

  assign pass_clean = crc_pass && !crc_fail;
  assign cond_ready = ready_ok(wr_q, dat0);
  assign cond_data  = data_ok(wd_q, dmet_q, pass_clean);
  assign gate_open  = cond_ready && cond_data;
  assign abort_ev   = pend_q && wd_q && !dmet_q && crc_fail;
  assign launch_ev  = pend_q && gate_open && !abort_ev;
  assign expire_ev  = pend_q && !gate_open && !abort_ev && (cnt_q == busy_limit);
  assign accept_ev  = !pend_q && cmd_req;

  assign cmd_launch  = launch_ev;
  assign cmd_abort   = abort_ev;
  assign cmd_timeout = expire_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wr_q   <= 1'b0;
      wd_q   <= 1'b0;
      dmet_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_ev) begin
      pend_q <= 1'b1;
      wr_q   <= wait_ready;
      wd_q   <= wait_data;
      dmet_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch_ev || abort_ev || expire_ev) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      dmet_q <= dmet_q || pass_clean;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R1
  no_wait_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && cmd_req && !wait_ready && !wait_data) |=> cmd_launch);
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && wr_q && !dat0) |-> !cmd_launch);
  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_launch, cmd_abort, cmd_timeout}));
  // R5
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> !cmd_launch);
  // R7
  opts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && $past(pend_q)) |-> $stable({wr_q, wd_q}));

endmodule

// File: rtl/sdg_crc_token.sv
`timescale 1ns/1ps
module sdg_crc_token (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_wr_done,
  input  logic skip_token,
  input  logic dat0,
  output logic wst_valid,
  output logic wst_err
);
  import sdg_pkg::*;

  localparam logic [1:0] LAST_IDX = 2'(TOK_STAT_W - 1);

  tok_st_t               st_q;
  logic [1:0]            bidx_q;
  logic [TOK_STAT_W-1:0] bits_q;
  logic                  vld_q, err_q;

  logic arm_ev, start_ev, end_ev;
  assign arm_ev   = (st_q == TK_IDLE) && blk_wr_done && !skip_token;
  assign start_ev = (st_q == TK_HUNT) && !dat0;
  assign end_ev   = (st_q == TK_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= TK_IDLE;
      bidx_q <= '0;
      bits_q <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (st_q)
        TK_IDLE: if (arm_ev) st_q <= TK_HUNT;
        TK_HUNT: if (start_ev) begin
          st_q   <= TK_BITS;
          bidx_q <= '0;
        end
        TK_BITS: begin
          bits_q <= {bits_q[TOK_STAT_W-2:0], dat0};
          if (bidx_q == LAST_IDX) st_q <= TK_END;
          else                    bidx_q <= bidx_q + 1'b1;
        end
        TK_END: begin
          vld_q <= 1'b1;
          err_q <= tok_rejected(bits_q, dat0);
          st_q  <= TK_IDLE;
        end
        default: st_q <= TK_IDLE;
      endcase
    end
  end

  assign wst_valid = vld_q;
  assign wst_err   = err_q;

  // R8
  single_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wst_valid |=> !wst_valid);
  // R8
  result_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_ev |=> wst_valid);
  // R9
  skip_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == TK_IDLE) && blk_wr_done && skip_token) |=> (st_q == TK_IDLE));

endmodule

// File: rtl/sdg_irq_watch.sv
`timescale 1ns/1ps
module sdg_irq_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic xfer_active,
  input  logic dat1,
  input  logic irq_clr,
  output logic sdio_irq
);
  logic flag_q;
  logic seen_ev;

  assign seen_ev = irq_en && !xfer_active && !dat1;

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (seen_ev)   flag_q <= 1'b1;
    else if (irq_clr)   flag_q <= 1'b0;
  end

  assign sdio_irq = flag_q;

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !xfer_active && !dat1) |=> sdio_irq);
  // R11
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdio_irq) |-> $past(irq_clr));
  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdio_irq && (!irq_en || xfer_active)) |=> !sdio_irq);

endmodule

// File: rtl/sdcmd_issue_gate.sv
`timescale 1ns/1ps
module sdcmd_issue_gate #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_req,
  input  logic             wait_ready,
  input  logic             wait_data,
  input  logic [TMO_W-1:0] busy_limit,
  input  logic             crc_pass,
  input  logic             crc_fail,
  input  logic             blk_wr_done,
  input  logic             skip_token,
  input  logic             dat0,
  input  logic             dat1,
  input  logic             xfer_active,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             cmd_launch,
  output logic             cmd_abort,
  output logic             cmd_timeout,
  output logic             wst_valid,
  output logic             wst_err,
  output logic             sdio_irq
);

  sdg_launch_ctl #(.TMO_W(TMO_W)) u_launch (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_req     (cmd_req),
    .wait_ready  (wait_ready),
    .wait_data   (wait_data),
    .busy_limit  (busy_limit),
    .crc_pass    (crc_pass),
    .crc_fail    (crc_fail),
    .dat0        (dat0),
    .cmd_launch  (cmd_launch),
    .cmd_abort   (cmd_abort),
    .cmd_timeout (cmd_timeout)
  );

  sdg_crc_token u_token (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_wr_done (blk_wr_done),
    .skip_token  (skip_token),
    .dat0        (dat0),
    .wst_valid   (wst_valid),
    .wst_err     (wst_err)
  );

  sdg_irq_watch u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_en      (irq_en),
    .xfer_active (xfer_active),
    .dat1        (dat1),
    .irq_clr     (irq_clr),
    .sdio_irq    (sdio_irq)
  );

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || !(cmd_abort || wst_valid)));

endmodule

// File: tb/test_sdcmd_issue_gate.sv
`timescale 1ns/1ps
module test_sdcmd_issue_gate;
  localparam int TW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n, cmd_req, wait_ready, wait_data, crc_pass, crc_fail;
  logic blk_wr_done, skip_token, dat0, dat1, xfer_active, irq_en, irq_clr;
  logic [TW-1:0] busy_limit;
  logic cmd_launch, cmd_abort, cmd_timeout, wst_valid, wst_err, sdio_irq;

  sdcmd_issue_gate #(.TMO_W(TW)) i_sdcmd_issue_gate (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .wait_ready(wait_ready),
    .wait_data(wait_data), .busy_limit(busy_limit), .crc_pass(crc_pass),
    .crc_fail(crc_fail), .blk_wr_done(blk_wr_done), .skip_token(skip_token),
    .dat0(dat0), .dat1(dat1), .xfer_active(xfer_active), .irq_en(irq_en),
    .irq_clr(irq_clr), .cmd_launch(cmd_launch), .cmd_abort(cmd_abort),
    .cmd_timeout(cmd_timeout), .wst_valid(wst_valid), .wst_err(wst_err),
    .sdio_irq(sdio_irq)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R12";

  // reference model state
  bit m_pend, m_wr, m_wd, m_seen;
  int m_wait;
  int m_tphase;          // 0 idle, 1 waiting start, 2 status, 3 end bit
  int m_tidx;
  int m_stat;
  bit m_vld, m_err, m_irq;

  task automatic chk(string nm, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, nm, got, exp, $time);
    end
  endtask

  task automatic tick();
    bit pass_ok, rdy, dat_ok, ab, go, lau, tmo;
    @(negedge clk);
    #2;
    if (!rst_n) begin
      chk("cmd_launch", cmd_launch, 1'b0);
      chk("cmd_abort", cmd_abort, 1'b0);
      chk("cmd_timeout", cmd_timeout, 1'b0);
      chk("wst_valid", wst_valid, 1'b0);
      chk("wst_err", wst_err, 1'b0);
      chk("sdio_irq", sdio_irq, 1'b0);
      @(posedge clk); #1;
      m_pend = 0; m_wr = 0; m_wd = 0; m_seen = 0; m_wait = 0;
      m_tphase = 0; m_tidx = 0; m_stat = 0; m_vld = 0; m_err = 0; m_irq = 0;
      return;
    end
    pass_ok = crc_pass && !crc_fail;
    rdy     = !m_wr || (dat0 == 1'b1);
    dat_ok  = !m_wd || m_seen || pass_ok;
    ab      = m_pend && m_wd && !m_seen && crc_fail;
    go      = rdy && dat_ok;
    lau     = m_pend && go && !ab;
    tmo     = m_pend && !go && !ab && (m_wait == int'(busy_limit));
    chk("cmd_launch", cmd_launch, lau);
    chk("cmd_abort", cmd_abort, ab);
    chk("cmd_timeout", cmd_timeout, tmo);
    chk("wst_valid", wst_valid, m_vld);
    chk("wst_err", wst_err, m_err);
    chk("sdio_irq", sdio_irq, m_irq);
    @(posedge clk); #1;
    // launch model
    if (!m_pend) begin
      if (cmd_req) begin
        m_pend = 1; m_wr = wait_ready; m_wd = wait_data; m_seen = 0; m_wait = 0;
      end
    end else if (lau || ab || tmo) m_pend = 0;
    else begin
      if (pass_ok) m_seen = 1;
      m_wait++;
    end
    // token model
    m_vld = 0;
    case (m_tphase)
      0: if (blk_wr_done && !skip_token) m_tphase = 1;
      1: if (!dat0) begin m_tphase = 2; m_tidx = 0; m_stat = 0; end
      2: begin
        m_stat = m_stat * 2 + (dat0 ? 1 : 0);
        m_tidx++;
        if (m_tidx == 3) m_tphase = 3;
      end
      default: begin
        m_vld = 1;
        m_err = !(m_stat == 2 && dat0);
        m_tphase = 0;
      end
    endcase
    // interrupt model
    if (irq_en && !xfer_active && !dat1) m_irq = 1;
    else if (irq_clr) m_irq = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic request(bit r, bit d);
    cmd_req = 1; wait_ready = r; wait_data = d;
    tick();
    cmd_req = 0; wait_ready = 0; wait_data = 0;
  endtask

  task automatic pulse_pass();
    crc_pass = 1; tick(); crc_pass = 0;
  endtask

  task automatic send_token(bit [4:0] pat);
    for (int i = 4; i >= 0; i--) begin dat0 = pat[i]; tick(); end
    dat0 = 1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog expired", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_req = 0; wait_ready = 0; wait_data = 0; crc_pass = 0;
    crc_fail = 0; blk_wr_done = 0; skip_token = 0; dat0 = 1; dat1 = 1;
    xfer_active = 0; irq_en = 0; irq_clr = 0; busy_limit = 16'd40;
    // R12 reset state
    cur_req = "R12"; ticks(3);
    rst_n = 1; ticks(2);

    // R1 immediate launch, twice back to back
    cur_req = "R1"; request(0, 0); ticks(1); request(0, 0); ticks(3);

    // R2 busy hold then release
    cur_req = "R2"; dat0 = 0; request(1, 0); ticks(5); dat0 = 1; ticks(3);
    // R2 card already ready
    request(1, 0); ticks(2);

    // R3 stale pass before request ignored, then pass releases
    cur_req = "R3"; pulse_pass(); request(0, 1); ticks(4); pulse_pass(); ticks(3);
    // R3 pass with fail same cycle is not clean
    request(0, 1); ticks(1); crc_pass = 1; crc_fail = 1; tick();
    crc_pass = 0; crc_fail = 0; ticks(2);

    // R4 pass while busy remembered, launch on release
    cur_req = "R4"; dat0 = 0; request(1, 1); ticks(2); pulse_pass(); ticks(3);
    dat0 = 1; ticks(3);
    // R4 ready first, data later
    request(1, 1); ticks(3); pulse_pass(); ticks(2);

    // R5 failure during data wait
    cur_req = "R5"; request(0, 1); ticks(3); crc_fail = 1; tick(); crc_fail = 0; ticks(4);
    // R5 failure after pass has no effect, waits on busy
    dat0 = 0; request(1, 1); pulse_pass(); crc_fail = 1; tick(); crc_fail = 0;
    ticks(2); dat0 = 1; ticks(3);

    // R6 timeout at limit
    cur_req = "R6"; busy_limit = 16'd3; dat0 = 0; request(1, 0); ticks(8);
    dat0 = 1; ticks(2);
    // R6 limit zero with data wait
    busy_limit = 16'd0; request(0, 1); ticks(3);
    // R6 release exactly at limit cycle launches
    busy_limit = 16'd2; dat0 = 0; request(1, 0); ticks(2); dat0 = 1; ticks(3);
    busy_limit = 16'd40;

    // R7 requests while pending ignored
    cur_req = "R7"; dat0 = 0; request(1, 0); request(0, 0); request(0, 1);
    ticks(2); dat0 = 1; ticks(3);

    // R8 accepted token, rejected status, bad end bit
    cur_req = "R8";
    blk_wr_done = 1; tick(); blk_wr_done = 0; ticks(3);
    send_token(5'b00101); ticks(3);
    blk_wr_done = 1; tick(); blk_wr_done = 0; ticks(1);
    send_token(5'b01011); ticks(3);
    blk_wr_done = 1; tick(); blk_wr_done = 0;
    send_token(5'b00100); ticks(3);
    blk_wr_done = 1; tick(); blk_wr_done = 0;
    send_token(5'b00101); ticks(3);

    // R9 skipped token with hostile DAT0 pattern
    cur_req = "R9"; blk_wr_done = 1; skip_token = 1; tick();
    blk_wr_done = 0; skip_token = 0;
    send_token(5'b01111); ticks(6);

    // R10 / R11 interrupt flag
    cur_req = "R11"; irq_en = 1; dat1 = 0; xfer_active = 1; ticks(3);
    irq_en = 0; xfer_active = 0; ticks(3);
    cur_req = "R10"; irq_en = 1; tick(); dat1 = 1; ticks(3);
    cur_req = "R11"; irq_clr = 1; tick(); irq_clr = 0; ticks(2);
    dat1 = 0; irq_clr = 1; ticks(2); irq_clr = 0; dat1 = 1; ticks(2);
    irq_clr = 1; tick(); irq_clr = 0; irq_en = 0; dat1 = 0; ticks(3);
    dat1 = 1; ticks(2);

    // R12 reset in mid-wait
    cur_req = "R12"; dat0 = 0; request(1, 0); rst_n = 0; ticks(2);
    rst_n = 1; dat0 = 1; ticks(3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule